// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Output Register

This block is a behavioural synchronous SRAM. It has a small parameterised depth and four byte lanes. Every command, address and write-data input is captured on the rising clock edge. A load strobe together with the chip select starts an access at a new address. Later cycles without the load strobe continue that access through a two-bit burst counter. The counter steps through the four words of an aligned group, in either a linear or an XOR-interleaved order. Each cycle is a read or a write according to the write inputs sampled in that cycle.

Read data leaves the array in one of two ways, chosen by a mode input. In flow-through mode it comes straight from the array. In pipelined mode it passes through an output register. Deselects and writes shut the drivers one stage earlier than a read would reach them, so in pipelined mode the last read beat needs a following read cycle (a dummy read, possibly with the output enable low) to be seen. The output enable acts without the clock. A sleep input puts the device in standby: commands are ignored and the contents are kept. After wake-up, a fixed number of recovery cycles pass before commands are taken again. The tri-state data bus is split into a read-data output and a drive-enable output.

Top module: `burst_sram`

## Requirements
- R1: A load with chip select high captures the address. In flow-through mode (`pipe_mode`=0) the read word and `rdrive`=1 appear right after the capturing edge. In pipelined mode they appear one edge later, and `rdrive` is 0 right after the capturing edge when the previous cycle was not a read.
- R2: In linear order (`linear`=1), the low two address bits of beat n are (base + n) mod 4. The count advances only on continue cycles with `adv`=1. A continue cycle with `adv`=0 repeats the same word.
- R3: In interleaved order (`linear`=0), the low two address bits of beat n are base XOR n. The upper address bits stay fixed throughout a burst.
- R4: `wr_all`=1 writes all four lanes with `wdata`, whatever `wr_byte` and `byte_en` are. Lane i is `wdata[8i+7:8i]`.
- R5: With `wr_all`=0 and `wr_byte`=1, exactly the lanes whose `byte_en` bit is 1 are written. With `wr_byte`=0, or with `byte_en`=0, the cycle is a read that returns all four lanes.
- R6: After any edge that captures a write, `rdrive` is 0 in both modes.
- R7: After an edge that captures a deselect (load with chip select low), `rdrive` is 0 at once. In pipelined mode this removes the beat of a read captured one edge earlier.
- R8: `oe`=0 forces `rdrive` to 0 without waiting for a clock edge. A read made with `oe`=0 still advances the burst counter exactly like a driven read.
- R9: While `sleep`=1, commands are ignored, nothing is written, `rdrive` is 0 and the stored data are kept. After `sleep` falls, the next WAKE_CYC edges are also ignored.
- R10: After reset the device is deselected with `rdrive`=0. A continue cycle without an earlier load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Standby request, active high |
| oe | input | 1 | Asynchronous output enable, active high |
| cs | input | 1 | Chip select, sampled with `ld` |
| ld | input | 1 | Load a new address |
| adv | input | 1 | Advance the burst counter on continue cycles |
| wr_all | input | 1 | Write all lanes |
| wr_byte | input | 1 | Write the lanes selected by `byte_en` |
| byte_en | input | LANES | Per-lane write select |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, captured with the command |
| rdata | output | LANES*LANE_W | Read data, zero when not driving |
| rdrive | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is the single-cycle deselect race. In pipelined mode a read must be captured and then followed, on the very next edge, by a deselect or a write. Only then does the early shutdown visibly remove a beat that was already registered. The bench builds both this sequence and the matching read-then-read sequence, so the beat is shown to be removed in one case and present in the other. The sleep recovery window is reached by issuing conflicting writes during sleep and during the recovery edges, then reading back the old word on the first edge that is accepted again.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BURST_W  = 2,
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              cs,
  input  logic              adv,
  input  logic              linear,
  input  logic              sleep,
  input  logic              wr_all,
  input  logic              wr_byte,
  input  logic [LANES-1:0]  byte_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic              rd_q,
  output logic [BURST_W-1:0] cnt_q
);
  localparam int WK_W = $clog2(WAKE_CYC + 2);

  logic              active_q, active_nx;
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [BURST_W-1:0] cnt_nx, low_nx;
  logic [WK_W-1:0]   wake_q, wake_nx;
  op_e               op_q, op_nx;
  logic              blocked, start, cont, go, is_wr;
  logic [LANES-1:0]  wmask;

  always_comb begin
    blocked = sleep | (wake_q != '0);
    wmask   = wr_all ? '1 : (wr_byte ? byte_en : '0);
    is_wr   = |wmask;
    start   = !blocked & ld & cs;
    cont    = !blocked & !ld & active_q;
    go      = start | cont;
    base_nx = start ? addr : base_q;
    if (start)            cnt_nx = '0;
    else if (cont && adv) cnt_nx = cnt_q + 1'b1;
    else                  cnt_nx = cnt_q;
    low_nx   = linear ? (base_nx[BURST_W-1:0] + cnt_nx) : (base_nx[BURST_W-1:0] ^ cnt_nx);
    acc_addr = {base_nx[ADDR_W-1:BURST_W], low_nx};
    op_nx    = go ? (is_wr ? OP_WRITE : OP_READ) : OP_IDLE;
    if (go)                active_nx = 1'b1;
    else if (blocked || ld) active_nx = 1'b0;
    else                   active_nx = active_q;
    lane_we = (go && is_wr) ? wmask : '0;
    if (sleep)               wake_nx = WK_W'(WAKE_CYC);
    else if (wake_q != '0)   wake_nx = wake_q - 1'b1;
    else                     wake_nx = wake_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      op_q      <= OP_IDLE;
      rd_addr_q <= '0;
      wake_q    <= '0;
    end else begin
      active_q <= active_nx;
      op_q     <= op_nx;
      wake_q   <= wake_nx;
      cnt_q    <= cnt_nx;
      if (start) base_q    <= base_nx;
      if (go)    rd_addr_q <= acc_addr;
    end
  end

  assign rd_q = (op_q == OP_READ);
endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_out.sv
module burst_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);
  logic              pv_q;
  logic [DATA_W-1:0] dout_q;
  logic              valid;
  logic [DATA_W-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      pv_q <= rd_q;
      if (rd_q) dout_q <= arr_data;
    end
  end

  always_comb begin
    valid  = pipe_mode ? (pv_q & rd_q) : rd_q;
    data   = pipe_mode ? dout_q : arr_data;
    rdrive = oe & valid;
    rdata  = rdrive ? data : '0;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W   = 6,
  parameter int BURST_W  = 2,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    linear,
  input  logic                    sleep,
  input  logic                    oe,
  input  logic                    cs,
  input  logic                    ld,
  input  logic                    adv,
  input  logic                    wr_all,
  input  logic                    wr_byte,
  input  logic [LANES-1:0]        byte_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]   lane_we;
  logic [ADDR_W-1:0]  acc_addr, rd_addr_q;
  logic               rd_q;
  logic [BURST_W-1:0] cnt_q;
  logic [DATA_W-1:0]  arr_data;

  burst_seq #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES), .WAKE_CYC(WAKE_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .ld(ld), .cs(cs), .adv(adv), .linear(linear),
    .sleep(sleep), .wr_all(wr_all), .wr_byte(wr_byte), .byte_en(byte_en),
    .addr(addr), .lane_we(lane_we), .acc_addr(acc_addr), .rd_addr_q(rd_addr_q),
    .rd_q(rd_q), .cnt_q(cnt_q)
  );

  burst_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) i_array (
    .clk(clk), .we(lane_we), .waddr(acc_addr), .wdata(wdata),
    .raddr(rd_addr_q), .rdata(arr_data)
  );

  burst_out #(
    .DATA_W(DATA_W)
  ) i_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .rd_q(rd_q),
    .arr_data(arr_data), .rdata(rdata), .rdrive(rdrive)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oe,
  input logic               sleep,
  input logic               ld,
  input logic               cs,
  input logic               adv,
  input logic [LANES-1:0]   lane_we,
  input logic [BURST_W-1:0] cnt_q,
  input logic               rdrive
);
  // R8: output enable low silences the bus
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !rdrive);
  // R9: sleep captured means no drive afterwards
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> !rdrive);
  // R9: no lane written while asleep
  p_sleep_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> (lane_we == '0));
  // R7: deselect shuts drivers right after capture
  p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n) (ld && !cs) |=> !rdrive);
  // R6: write capture leaves the bus undriven
  p_wr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n) (lane_we != '0) |=> !rdrive);
  // R2: counter holds on cycles without load or advance
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) (!ld && !adv) |=> $stable(cnt_q));
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES), .BURST_W(BURST_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .oe(oe), .sleep(sleep), .ld(ld), .cs(cs), .adv(adv),
  .lane_we(lane_we), .cnt_q(cnt_q), .rdrive(rdrive)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, pipe_mode, linear, sleep, oe, cs, ld, adv, wr_all, wr_byte;
  logic [NL-1:0] byte_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdrive;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [64];

  // {wr_all, wr_byte, byte_en[3:0], addr[5:0], wdata[31:0]}
  localparam logic [43:0] VEC [8] = '{
    {1'b1, 1'b0, 4'b0000, 6'd5,  32'h11223344},
    {1'b0, 1'b1, 4'b0001, 6'd5,  32'hAAAAAAAA},
    {1'b0, 1'b1, 4'b1010, 6'd5,  32'h55667788},
    {1'b1, 1'b1, 4'b0000, 6'd9,  32'hDEADBEEF},
    {1'b0, 1'b1, 4'b0000, 6'd9,  32'h00000000},
    {1'b0, 1'b0, 4'b1111, 6'd9,  32'h00000000},
    {1'b0, 1'b1, 4'b1111, 6'd63, 32'hCAFEF00D},
    {1'b0, 1'b1, 4'b0110, 6'd63, 32'h12345678}
  };

  burst_sram i_burst_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .linear(linear), .sleep(sleep),
    .oe(oe), .cs(cs), .ld(ld), .adv(adv), .wr_all(wr_all), .wr_byte(wr_byte),
    .byte_en(byte_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rdrive(rdrive)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic op(input logic l, input logic c, input logic a, input logic wa,
                    input logic wb, input logic [NL-1:0] be, input logic [AW-1:0] ad,
                    input logic [DW-1:0] d);
    ld = l; cs = c; adv = a; wr_all = wa; wr_byte = wb; byte_en = be; addr = ad; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ref_wr(input logic [AW-1:0] ad, input logic [DW-1:0] d,
                        input logic wa, input logic wb, input logic [NL-1:0] be);
    for (int i = 0; i < NL; i++)
      if (wa || (wb && be[i])) ref_mem[ad][8*i +: 8] = d[8*i +: 8];
  endtask

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input int n, input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + 2'(n)) : (b[1:0] ^ 2'(n));
    return {b[AW-1:2], lo};
  endfunction

  task automatic burst_read(input logic [AW-1:0] b, input logic pm, input logic lin, input string tag);
    pipe_mode = pm; linear = lin;
    op(1, 1, 0, 0, 0, '0, b, '0);
    if (!pm) check({tag, " beat0"}, rdata, ref_mem[beat(b, 0, lin)]);
    else     check("R1 pipelined first edge no drive", {31'd0, rdrive}, 32'd0);
    for (int i = 1; i < 4; i++) begin
      op(0, 0, 1, 0, 0, '0, '0, '0);
      if (!pm) check(tag, rdata, ref_mem[beat(b, i, lin)]);
      else     check(tag, rdata, ref_mem[beat(b, i - 1, lin)]);
    end
    if (pm) begin
      op(0, 0, 0, 0, 0, '0, '0, '0);
      check({tag, " last beat"}, rdata, ref_mem[beat(b, 3, lin)]);
    end
    op(1, 0, 0, 0, 0, '0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; pipe_mode = 0; linear = 1; sleep = 0; oe = 1;
    ld = 0; cs = 0; adv = 0; wr_all = 0; wr_byte = 0; byte_en = '0; addr = '0; wdata = '0;
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10: quiet after reset, continue without load does nothing
    check("R10 reset drive", {31'd0, rdrive}, 32'd0);
    op(0, 0, 1, 0, 0, '0, '0, '0);
    check("R10 continue without load", {31'd0, rdrive}, 32'd0);

    // initialise words used below
    for (int i = 0; i < 64; i++) begin
      op(1, 1, 0, 1, 0, '0, 6'(i), 32'h5A000000 + 32'(i));
      ref_wr(6'(i), 32'h5A000000 + 32'(i), 1, 0, '0);
    end

    // table of write/readback vectors, flow-through
    pipe_mode = 0;
    for (int i = 0; i < 8; i++) begin
      logic wa, wb, isw;
      logic [NL-1:0] be;
      logic [AW-1:0] ad;
      logic [DW-1:0] d;
      {wa, wb, be, ad, d} = VEC[i];
      isw = wa || (wb && (be != '0));
      op(1, 1, 0, wa, wb, be, ad, d);
      if (isw) begin
        check("R6 write leaves bus undriven", {31'd0, rdrive}, 32'd0);
        ref_wr(ad, d, wa, wb, be);
      end else begin
        check("R5 empty write is read", rdata, ref_mem[ad]);
      end
      op(1, 1, 0, 0, 0, '0, ad, '0);
      check(wa ? "R4 global write readback" : "R5 byte write readback", rdata, ref_mem[ad]);
      check("R1 flow drive", {31'd0, rdrive}, 32'd1);
    end
    op(1, 0, 0, 0, 0, '0, '0, '0);

    // burst writes in both orders
    linear = 1;
    for (int i = 0; i < 4; i++) begin
      op(i == 0, 1, i != 0, 1, 0, '0, 6'h10, 32'hB1000000 + 32'(i));
      ref_wr(beat(6'h10, i, 1), 32'hB1000000 + 32'(i), 1, 0, '0);
    end
    linear = 0;
    for (int i = 0; i < 4; i++) begin
      op(i == 0, 1, i != 0, 1, 0, '0, 6'h26, 32'hC2000000 + 32'(i));
      ref_wr(beat(6'h26, i, 0), 32'hC2000000 + 32'(i), 1, 0, '0);
    end
    op(1, 0, 0, 0, 0, '0, '0, '0);

    burst_read(6'h12, 0, 1, "R2 linear flow");
    burst_read(6'h13, 1, 1, "R2 linear pipe");
    burst_read(6'h25, 0, 0, "R3 interleaved flow");
    burst_read(6'h27, 1, 0, "R3 interleaved pipe");

    // R2 hold without advance
    pipe_mode = 0; linear = 1;
    op(1, 1, 0, 0, 0, '0, 6'h11, '0);
    check("R2 hold beat0", rdata, ref_mem[6'h11]);
    op(0, 0, 0, 0, 0, '0, '0, '0);
    check("R2 hold repeats word", rdata, ref_mem[6'h11]);
    op(0, 0, 1, 0, 0, '0, '0, '0);
    check("R2 advance after hold", rdata, ref_mem[6'h12]);

    // R6 pipelined: read then write removes beat
    pipe_mode = 1;
    op(1, 0, 0, 0, 0, '0, '0, '0);
    op(1, 1, 0, 0, 0, '0, 6'h10, '0);
    op(1, 1, 0, 1, 0, '0, 6'h20, 32'h0BADCAFE);
    ref_wr(6'h20, 32'h0BADCAFE, 1, 0, '0);
    check("R6 pipelined write after read", {31'd0, rdrive}, 32'd0);

    // R7 single-cycle deselect versus read-read
    op(1, 1, 0, 0, 0, '0, 6'h10, '0);
    op(1, 0, 0, 0, 0, '0, '0, '0);
    check("R7 deselect removes pipelined beat", {31'd0, rdrive}, 32'd0);
    op(1, 1, 0, 0, 0, '0, 6'h10, '0);
    op(0, 0, 0, 0, 0, '0, '0, '0);
    check("R7 read-read keeps beat", rdata, ref_mem[6'h10]);
    op(1, 0, 0, 0, 0, '0, '0, '0);

    // R8 dummy reads advance the counter, oe acts without a clock
    pipe_mode = 0; linear = 1; oe = 0;
    op(1, 1, 0, 0, 0, '0, 6'h10, '0);
    check("R8 oe low no drive", {31'd0, rdrive}, 32'd0);
    op(0, 0, 1, 0, 0, '0, '0, '0);
    oe = 1;
    op(0, 0, 1, 0, 0, '0, '0, '0);
    check("R8 dummy reads advanced", rdata, ref_mem[6'h12]);
    #1 oe = 0;
    #0.5 check("R8 async oe off", {31'd0, rdrive}, 32'd0);
    oe = 1;
    #0.5 check("R8 async oe on", rdata, ref_mem[6'h12]);
    op(1, 0, 0, 0, 0, '0, '0, '0);

    // R9 sleep and recovery window (WAKE_CYC = 2)
    sleep = 1;
    op(1, 1, 0, 1, 0, '0, 6'h30, 32'hFFFFFFFF);
    op(1, 1, 0, 0, 0, '0, 6'h30, '0);
    check("R9 read ignored in sleep", {31'd0, rdrive}, 32'd0);
    sleep = 0;
    op(1, 1, 0, 1, 0, '0, 6'h30, 32'hEEEEEEEE);
    op(1, 1, 0, 0, 0, '0, 6'h30, '0);
    check("R9 read ignored in recovery", {31'd0, rdrive}, 32'd0);
    op(1, 1, 0, 0, 0, '0, 6'h30, '0);
    check("R9 data retained", rdata, ref_mem[6'h30]);
    check("R9 accepted after recovery", {31'd0, rdrive}, 32'd1);
    op(1, 0, 0, 0, 0, '0, '0, '0);

    finish_run();
  end
endmodule